// File: doc/BRIEF.md
# Variable-Width String Matching CAM

This block compares a byte stream against a fixed set of stored strings and reports which one has just arrived. Each clock it takes one byte into a shift register, and every position of that register feeds the comparators of every stored word at once. Each word has its own byte length, taken from a per-word length parameter array. Strings of different lengths are therefore matched against the same stream in the same cycle. The word count may be any positive integer.

A word hits when match enable was high and its most recent bytes equal its stored string. A priority encoder turns the hit vector into a registered match flag and a binary word index. The string contents live in registers written one byte at a time through a small write port. Stored contents have no reset, so they must be written before they are used.

Top module: `strMatchCam`

## Requirements
- R1: A synchronous reset clears the shift register and both output registers: `matchOut` reads 0 and `addrOut` reads 0 after the reset edge.
- R2: Word w of length L hits when the last L bytes received equal its stored bytes, with stored byte 0 compared against the oldest of those L bytes and byte L-1 against the newest.
- R3: Each word compares exactly its own length, so bytes received before its last L bytes have no effect on its result. Words of different lengths are evaluated in the same cycle.
- R4: When match enable was low for a byte, the result for that byte has `matchOut` = 0 and `addrOut` = 0.
- R5: A byte and match enable applied before clock edge k produce their result in `matchOut`/`addrOut` after edge k+1, and a fresh result follows every cycle.
- R6: When no word hits, `addrOut` is 0 and `matchOut` is 0.
- R7: If several words hit in the same cycle, `addrOut` is the lowest hitting word index.
- R8: With `wrEn` high, `wrData` is stored as byte `wrIdx` of word `wrWord` at the clock edge. A result registered at that same edge still uses the contents from before the write.
- R9: A write whose `wrWord` is not below the word count, or whose `wrIdx` is not below that word's length, changes nothing.
- R10: The word count need not be a power of two. `addrOut` is ceil(log2(word count)) bits wide, and a hit reports the word's index in binary, including indices above the last power of two (index 4 of 5 words).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 8 | Stream byte, one per clock |
| matchEn | input | 1 | Allows the byte presented with it to produce a hit |
| wrEn | input | 1 | Write strobe for stored contents |
| wrWord | input | AW (3) | Word index to write |
| wrIdx | input | IW (4) | Byte position within the word to write |
| wrData | input | 8 | Byte value to store |
| matchOut | output | 1 | A stored word matched |
| addrOut | output | AW (3) | Binary index of the matching word |

## Verification
A content write and the registering of a comparison result can happen at the same clock edge, and both may concern the same word. The bench provokes this by completing a stored string in the stream and then writing a changed byte into that word on the following cycle, which is the cycle the result is registered. The result at that edge must still report the hit against the old contents, and a second pass of the same string must miss. Beyond that case, a bench-side model of the shift history and stored contents predicts every output cycle by cycle across directed strings and a long pseudo-random stream.

// File: rtl/camPkg.sv
package camPkg;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic evalEn;   // registered match enable, aligned with the shift register
    logic wrValid;  // write request that passed range checks
  } camStrobe_t;

endpackage

// File: rtl/camControl.sv
module camControl
  import camPkg::*;
#(
  parameter int NUM_WORDS = 5,
  parameter int WORD_LEN [NUM_WORDS] = '{default: 4},
  parameter int AW = 3,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          matchEn,
  input  logic          wrEn,
  input  logic [AW-1:0] wrWord,
  input  logic [IW-1:0] wrIdx,
  output camStrobe_t    strobe
);

  logic enReg;
  logic wrOk;

  always_ff @(posedge clk) begin
    if (rst) enReg <= 1'b0;
    else     enReg <= matchEn;
  end

  // A write is accepted only for an existing word and a byte inside its length
  always_comb begin
    wrOk = 1'b0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wrWord == AW'(w) && int'(wrIdx) < WORD_LEN[w]) wrOk = 1'b1;
    end
  end

  assign strobe.evalEn  = enReg;
  assign strobe.wrValid = wrEn & wrOk;

endmodule

// File: rtl/camDatapath.sv
module camDatapath
  import camPkg::*;
#(
  parameter int NUM_WORDS = 5,
  parameter int WORD_LEN [NUM_WORDS] = '{default: 4},
  parameter int DEPTH = 9,
  parameter int AW = 3,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  camStrobe_t    strobe,
  input  logic [7:0]    dataIn,
  input  logic [AW-1:0] wrWord,
  input  logic [IW-1:0] wrIdx,
  input  logic [7:0]    wrData,
  output logic          matchOut,
  output logic [AW-1:0] addrOut
);

  logic [7:0] taps [DEPTH];
  logic [NUM_WORDS-1:0] wordHit;
  logic          anyHit;
  logic [AW-1:0] hitIdx;

  // Tap 0 holds the newest byte
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) taps[i] <= 8'd0;
    end else begin
      taps[0] <= dataIn;
      for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : gWord
    localparam int LEN = WORD_LEN[w];
    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (strobe.wrValid && wrWord == AW'(w)) store[wrIdx] <= wrData;
    end

    // Chain of byte compares seeded by the enable
    always_comb begin
      wordHit[w] = strobe.evalEn;
      for (int j = 0; j < LEN; j++) begin
        wordHit[w] = wordHit[w] & (store[j] == taps[LEN-1-j]);
      end
    end
  end

  // Priority encoder: lowest index wins, zero when nothing hits
  always_comb begin
    anyHit = 1'b0;
    hitIdx = '0;
    for (int w = NUM_WORDS - 1; w >= 0; w--) begin
      if (wordHit[w]) begin
        anyHit = 1'b1;
        hitIdx = AW'(w);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      matchOut <= 1'b0;
      addrOut  <= '0;
    end else begin
      matchOut <= anyHit;
      addrOut  <= hitIdx;
    end
  end

endmodule

// File: rtl/strMatchCam.sv
module strMatchCam
  import camPkg::*;
#(
  parameter int NUM_WORDS = 5,
  parameter int WORD_LEN [NUM_WORDS] = '{5, 9, 4, 6, 4},
  parameter int DEPTH = 9,
  localparam int AW = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    dataIn,
  input  logic          matchEn,
  input  logic          wrEn,
  input  logic [AW-1:0] wrWord,
  input  logic [IW-1:0] wrIdx,
  input  logic [7:0]    wrData,
  output logic          matchOut,
  output logic [AW-1:0] addrOut
);

  camStrobe_t strobe;

  camControl #(
    .NUM_WORDS(NUM_WORDS), .WORD_LEN(WORD_LEN), .AW(AW), .IW(IW)
  ) uCtrl (
    .clk(clk), .rst(rst), .matchEn(matchEn), .wrEn(wrEn),
    .wrWord(wrWord), .wrIdx(wrIdx), .strobe(strobe)
  );

  camDatapath #(
    .NUM_WORDS(NUM_WORDS), .WORD_LEN(WORD_LEN), .DEPTH(DEPTH), .AW(AW), .IW(IW)
  ) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .dataIn(dataIn),
    .wrWord(wrWord), .wrIdx(wrIdx), .wrData(wrData),
    .matchOut(matchOut), .addrOut(addrOut)
  );

endmodule

// File: rtl/camChecker.sv
module camChecker #(
  parameter int NUM_WORDS = 5,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          matchEn,
  input logic          matchOut,
  input logic [AW-1:0] addrOut
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst) sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!matchOut && addrOut == '0));

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3 && !$past(matchEn, 2)) |-> !matchOut);

  assert_hit_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3 && matchOut) |-> $past(matchEn, 2));

  assert_idle_addr_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != 2'd0 && !matchOut) |-> addrOut == '0);

  assert_addr_in_range_R10: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != 2'd0 && matchOut) |-> int'(addrOut) < NUM_WORDS);

endmodule

bind strMatchCam camChecker #(.NUM_WORDS(NUM_WORDS), .AW(AW)) uChk (
  .clk(clk), .rst(rst), .matchEn(matchEn), .matchOut(matchOut), .addrOut(addrOut)
);

// File: tb/sim_strMatchCam.sv
module sim_strMatchCam;

  localparam int NW = 5;
  localparam int DEPTH = 9;
  localparam int AW = 3;
  localparam int IW = 4;
  localparam int LENS [NW] = '{5, 9, 4, 6, 4};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    dataIn = 8'd0;
  logic          matchEn = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrWord = '0;
  logic [IW-1:0] wrIdx = '0;
  logic [7:0]    wrData = 8'd0;
  logic          matchOut;
  logic [AW-1:0] addrOut;

  int total = 0;
  int bad = 0;

  // Bench model of history and contents
  logic [7:0] hist [DEPTH];
  logic [7:0] st [NW][DEPTH];
  logic       enPrev = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  strMatchCam u0 (
    .clk(clk), .rst(rst), .dataIn(dataIn), .matchEn(matchEn), .wrEn(wrEn),
    .wrWord(wrWord), .wrIdx(wrIdx), .wrData(wrData),
    .matchOut(matchOut), .addrOut(addrOut)
  );

  task automatic check(input string tag, input logic gotM, input logic [AW-1:0] gotA,
                       input logic expM, input logic [AW-1:0] expA);
    total++;
    if (gotM !== expM || gotA !== expA) begin
      bad++;
      $display("FAIL %s: got match=%0b addr=%0d expected match=%0b addr=%0d",
               tag, gotM, gotA, expM, expA);
    end
  endtask

  // One clock: drive inputs, predict the result registered at this edge, compare
  task automatic step(input logic [7:0] d, input logic en, input logic we,
                      input logic [AW-1:0] ww, input logic [IW-1:0] wi,
                      input logic [7:0] wd, input string tag);
    logic expM;
    logic [AW-1:0] expA;
    int hits;
    string t;
    dataIn = d; matchEn = en; wrEn = we; wrWord = ww; wrIdx = wi; wrData = wd;
    expM = 1'b0; expA = '0; hits = 0;
    for (int w = NW - 1; w >= 0; w--) begin
      logic ok;
      ok = enPrev;
      for (int j = 0; j < LENS[w]; j++) ok &= (st[w][j] == hist[LENS[w]-1-j]);
      if (ok) begin expM = 1'b1; expA = AW'(w); hits++; end
    end
    t = tag;
    if (t == "") begin
      if (!enPrev) t = "R4";
      else if (hits > 1) t = "R7";
      else if (expM) t = "R2";
      else t = "R6";
    end
    @(posedge clk);
    for (int i = DEPTH - 1; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = d;
    enPrev = en;
    if (we && int'(ww) < NW && int'(wi) < LENS[ww]) st[ww][wi] = wd;
    @(negedge clk);
    check(t, matchOut, addrOut, expM, expA);
  endtask

  task automatic feed(input string s, input logic en, input string tag);
    for (int i = 0; i < s.len(); i++) step(s[i], en, 1'b0, '0, '0, 8'd0, tag);
  endtask

  task automatic loadWord(input int w, input string s);
    for (int i = 0; i < s.len(); i++) step("a", 1'b0, 1'b1, AW'(w), IW'(i), s[i], "R8");
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) hist[i] = 8'd0;
    for (int w = 0; w < NW; w++) for (int j = 0; j < DEPTH; j++) st[w][j] = 8'hFF;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", matchOut, addrOut, 1'b0, '0);
    rst = 1'b0;

    loadWord(0, "HELLO");
    loadWord(1, "ABCDEFGHI");
    loadWord(2, "WXYZ");
    loadWord(3, "QRSTUV");
    loadWord(4, "MNOP");

    // R2: each string alone, then R5 flush cycles follow the final byte
    feed("xxHELLO", 1'b1, "R2");
    feed("xx", 1'b1, "R5");
    feed("ABCDEFGHI", 1'b1, "R2");
    feed("QRSTUVx", 1'b1, "R2");
    // R10: highest index of a non power-of-two count
    feed("MNOPx", 1'b1, "R10");
    // R3: older bytes before a short word are irrelevant
    feed("ZZZZWXYZ", 1'b1, "R3");
    feed("QRSTWXYZx", 1'b1, "R3");
    // R4: disabled stream must not hit
    feed("HELLOx", 1'b0, "R4");
    feed("WXYZ", 1'b1, "R5");
    feed("x", 1'b0, "R4");
    // R5: back-to-back strings give results on consecutive cycles
    feed("MNOPWXYZMNOPx", 1'b1, "R5");

    // R9: writes outside a word or outside its length change nothing
    step("a", 1'b1, 1'b1, 3'd5, 4'd0, "Q", "R9");
    step("a", 1'b1, 1'b1, 3'd7, 4'd1, "Q", "R9");
    step("a", 1'b1, 1'b1, 3'd2, 4'd4, "Q", "R9");
    step("a", 1'b1, 1'b1, 3'd4, 4'd8, "Q", "R9");
    feed("WXYZMNOPx", 1'b1, "R9");

    // R8: write into word 2 on the cycle its result is registered
    feed("WXYZ", 1'b1, "R8");
    step("k", 1'b1, 1'b1, 3'd2, 4'd0, "K", "R8");
    feed("WXYZx", 1'b1, "R8");
    feed("KXYZx", 1'b1, "R8");
    step("a", 1'b0, 1'b1, 3'd2, 4'd0, "W", "R8");

    // R7: make word 4 equal to word 2, both hit, lower index reported
    loadWord(4, "WXYZ");
    feed("WXYZx", 1'b1, "R7");
    // word 0 ending with the same four bytes plus word 2
    loadWord(0, "AWXYZ");
    feed("AWXYZx", 1'b1, "R7");

    // Pseudo-random sweep with injected strings and toggling enable
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[4:0] == 5'd3) begin
        case (lfsr[7:5] % 5)
          0: feed("AWXYZ", lfsr[8] | lfsr[9], "");
          1: feed("ABCDEFGHI", 1'b1, "");
          2: feed("WXYZ", lfsr[8] | lfsr[9], "");
          3: feed("QRSTUV", 1'b1, "");
          default: feed("MNOP", lfsr[8], "");
        endcase
      end else begin
        step(8'h41 + {5'd0, lfsr[2:0]} + {4'd0, lfsr[11:9], 1'b0}, lfsr[15] | lfsr[14], 1'b0, '0, '0, 8'd0, "");
      end
    end

    // R1: reset in mid stream clears outputs
    feed("WXY", 1'b1, "R2");
    rst = 1'b1;
    @(posedge clk);
    for (int i = 0; i < DEPTH; i++) hist[i] = 8'd0;
    enPrev = 1'b0;
    @(negedge clk);
    check("R1", matchOut, addrOut, 1'b0, '0);
    rst = 1'b0;
    feed("Zx", 1'b1, "R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule